// File: doc/BRIEF.md
# Endpoint Receive Control and Status Register

This block keeps the receive-side state of one full-speed USB device endpoint: a completion flag, the expected data toggle for the next packet, a 2-bit receive status, and a record of whether the last completed transaction was SETUP or OUT. Two parties change that state. The first is a protocol engine, which reports the end of each transaction with single-cycle strobes. The second is a CPU, which writes a register word.

The CPU write word gives each bit its own write rule. The completion flag can only be cleared, by writing 0 to it. The toggle bit and the status bits change only when a 1 is written, and then they invert. Because of these rules, software can write a word built from constants and never risks undoing a hardware update it has not yet seen. Hardware updates depend on the configured endpoint kind: control, bulk, interrupt or isochronous. The flag drives an endpoint interrupt at all times, and drives a generic interrupt when that interrupt is enabled.

Top module: `ep_rx_ctrl_status`

## Requirements
- R1: A completed OUT transaction on a bulk, control or interrupt endpoint sets the flag on the next clock edge when all three hold: the handshake is ACK, there is no error, and the data PID (`ev_data1`, 0 = DATA0) equals the current toggle. Writing 0 to `sw_wdata[3]` clears the flag. Writing 1 to it has no effect.
- R2: On a non-isochronous endpoint, no flag, toggle or status change follows an OUT completion in any of these cases: the handshake is NONE (00), NAK (10) or STALL (11); `ev_err` is set; or the data PID does not match the toggle.
- R3: A successful OUT transaction on a non-isochronous endpoint, as defined in R1, inverts the toggle.
- R4: On a control endpoint (`cfg_kind` 01), a SETUP completion clears the toggle. If that SETUP ends with ACK, no error and DATA0, the toggle ends at 1, the flag is set and `st_last_setup` becomes 1. A SETUP completion on any other endpoint kind changes nothing.
- R5: On an isochronous endpoint (`cfg_kind` 10), every OUT completion inverts the toggle whatever the handshake. The flag is set only when `ev_err` is 0.
- R6: In a CPU write, a 1 in `sw_wdata[2]` inverts the toggle and a 1 in `sw_wdata[1:0]` inverts the matching status bit. A 0 in any of these positions leaves that bit unchanged.
- R7: Every completion that sets the flag on a non-isochronous endpoint, whether OUT or SETUP, forces the status to NAK (10).
- R8: Hardware never changes the status of an isochronous endpoint.
- R9: The status encoding is 00 DISABLED, 01 STALL, 10 NAK, 11 VALID. After reset the flag, the toggle and `st_last_setup` are 0, and the status is DISABLED.
- R10: `irq_ep` equals the flag. `irq_gen` equals the flag AND `irq_en`. Both follow the flag in the same cycle.
- R11: If a hardware set of the flag and a CPU clear fall in the same cycle, the flag ends at 1. A CPU toggle written in the same cycle as a hardware update is applied on top of the hardware result.
- R12: `st_last_setup` is loaded only when the flag is set: 1 for SETUP, 0 for OUT. It holds its value at all other times.

Endpoint kind encoding: 00 bulk, 01 control, 10 isochronous, 11 interrupt. Handshake encoding: 00 none, 01 ACK, 10 NAK, 11 STALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_kind | input | 2 | Endpoint kind |
| irq_en | input | 1 | Generic interrupt enable |
| sw_wr | input | 1 | CPU write strobe |
| sw_wdata | input | STAT_W+2 | Write word: [3] flag clear-on-0, [2] toggle invert, [1:0] status invert |
| ev_done | input | 1 | Transaction-complete strobe |
| ev_setup | input | 1 | Completed transaction was SETUP (1) or OUT (0) |
| ev_data1 | input | 1 | Received data PID was DATA1 |
| ev_hs | input | 2 | Handshake returned |
| ev_err | input | 1 | Protocol or CRC error during the transaction |
| st_flag | output | 1 | Completion flag |
| st_toggle | output | 1 | Expected data toggle |
| st_stat | output | STAT_W | Receive status |
| st_last_setup | output | 1 | Last completion was SETUP |
| irq_ep | output | 1 | Endpoint interrupt condition |
| irq_gen | output | 1 | Generic interrupt request |

## Verification
The checker assumes that `ev_done` is a single-cycle strobe, and that `cfg_kind` stays constant over the cycle in which a completion is reported. Its status and toggle properties also require that no CPU write to the same bits arrives in that cycle. The stimulus holds every event input for exactly one clock and drives `cfg_kind` together with the strobe. It issues combined CPU and hardware updates only in dedicated collision cases, which the properties leave out through their antecedents.

// File: rtl/ep_rx_pkg.sv
package ep_rx_pkg;

   typedef enum logic [1:0] {
      KIND_BULK = 2'b00,
      KIND_CTRL = 2'b01,
      KIND_ISO  = 2'b10,
      KIND_INTR = 2'b11
   } ep_kind_e;

   typedef enum logic [1:0] {
      HS_NONE  = 2'b00,
      HS_ACK   = 2'b01,
      HS_NAK   = 2'b10,
      HS_STALL = 2'b11
   } hs_e;

   typedef enum logic [1:0] {
      RXS_DISABLED = 2'b00,
      RXS_STALL    = 2'b01,
      RXS_NAK      = 2'b10,
      RXS_VALID    = 2'b11
   } rx_stat_e;

   typedef struct packed {
      logic flag_set;
      logic tog_load;
      logic tog_val;
      logic nak_force;
      logic was_setup;
   } hw_upd_t;

endpackage

// File: rtl/ep_rx_evt_decode.sv
module ep_rx_evt_decode
   import ep_rx_pkg::*;
#(
   parameter int KIND_W = 2,
   parameter int HS_W   = 2
) (
   input  logic [KIND_W-1:0] kind,
   input  logic              done,
   input  logic              setup,
   input  logic              data1,
   input  logic [HS_W-1:0]   hs,
   input  logic              err,
   input  logic              cur_tog,
   output hw_upd_t           upd
);

   logic is_iso;
   logic is_ctl;
   logic ack_ok;
   logic setup_hit;
   logic out_hit;

   assign is_iso    = (kind == KIND_ISO);
   assign is_ctl    = (kind == KIND_CTRL);
   assign ack_ok    = (hs == HS_ACK) && !err;
   assign setup_hit = done && setup && is_ctl;
   assign out_hit   = done && !setup;

   always_comb begin
      upd = '0;
      upd.tog_val = cur_tog;
      if (setup_hit) begin
         upd.tog_load = 1'b1;
         upd.tog_val  = 1'b0;
         if (ack_ok && !data1) begin
            upd.tog_val   = 1'b1;
            upd.flag_set  = 1'b1;
            upd.nak_force = 1'b1;
            upd.was_setup = 1'b1;
         end
      end else if (out_hit && is_iso) begin
         upd.tog_load = 1'b1;
         upd.tog_val  = ~cur_tog;
         upd.flag_set = !err;
      end else if (out_hit && ack_ok && (data1 == cur_tog)) begin
         upd.tog_load  = 1'b1;
         upd.tog_val   = ~cur_tog;
         upd.flag_set  = 1'b1;
         upd.nak_force = 1'b1;
      end
   end

endmodule

// File: rtl/ep_rx_w0c_flag.sv
module ep_rx_w0c_flag #(
   parameter int SIDE_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_set,
   input  logic [SIDE_W-1:0] side_in,
   input  logic              sw_clr,
   output logic              flag_q,
   output logic [SIDE_W-1:0] side_q
);

   if (SIDE_W < 1) begin : g_bad_side
      $error("ep_rx_w0c_flag: SIDE_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         side_q <= '0;
      end else if (hw_set) begin
         flag_q <= 1'b1;
         side_q <= side_in;
      end else if (sw_clr) begin
         flag_q <= 1'b0;
      end
   end

endmodule

// File: rtl/ep_rx_tgl_bit.sv
module ep_rx_tgl_bit #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_load,
   input  logic hw_val,
   input  logic sw_flip,
   output logic q
);

   logic base;

   assign base = hw_load ? hw_val : q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST_VAL;
      end else begin
         q <= base ^ sw_flip;
      end
   end

endmodule

// File: rtl/ep_rx_ctrl_status.sv
module ep_rx_ctrl_status
   import ep_rx_pkg::*;
#(
   parameter int                STAT_W   = 2,
   parameter int                KIND_W   = 2,
   parameter int                HS_W     = 2,
   parameter logic              RST_TOG  = 1'b0,
   parameter logic [STAT_W-1:0] RST_STAT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [KIND_W-1:0] cfg_kind,
   input  logic              irq_en,
   input  logic              sw_wr,
   input  logic [STAT_W+1:0] sw_wdata,
   input  logic              ev_done,
   input  logic              ev_setup,
   input  logic              ev_data1,
   input  logic [HS_W-1:0]   ev_hs,
   input  logic              ev_err,
   output logic              st_flag,
   output logic              st_toggle,
   output logic [STAT_W-1:0] st_stat,
   output logic              st_last_setup,
   output logic              irq_ep,
   output logic              irq_gen
);

   localparam int WD_W     = STAT_W + 2;
   localparam int FLAG_POS = WD_W - 1;
   localparam int TOG_POS  = STAT_W;
   localparam int TGL_W    = STAT_W + 1;
   localparam logic [TGL_W-1:0] TGL_RST = {RST_TOG, RST_STAT};

   if (STAT_W != 2) begin : g_bad_stat
      $error("ep_rx_ctrl_status: STAT_W must be 2");
   end
   if (KIND_W != 2) begin : g_bad_kind
      $error("ep_rx_ctrl_status: KIND_W must be 2");
   end
   if (HS_W != 2) begin : g_bad_hs
      $error("ep_rx_ctrl_status: HS_W must be 2");
   end

   hw_upd_t           upd;
   logic [TGL_W-1:0]  tgl_q;
   logic [TGL_W-1:0]  tgl_load;
   logic [TGL_W-1:0]  tgl_val;
   logic [TGL_W-1:0]  tgl_flip;
   logic [STAT_W-1:0] nak_code;
   logic              sw_clr;

   ep_rx_evt_decode #(
      .KIND_W (KIND_W),
      .HS_W   (HS_W)
   ) dec_i (
      .kind    (cfg_kind),
      .done    (ev_done),
      .setup   (ev_setup),
      .data1   (ev_data1),
      .hs      (ev_hs),
      .err     (ev_err),
      .cur_tog (tgl_q[TOG_POS]),
      .upd     (upd)
   );

   assign sw_clr = sw_wr && !sw_wdata[FLAG_POS];

   ep_rx_w0c_flag #(
      .SIDE_W (1)
   ) flag_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set  (upd.flag_set),
      .side_in (upd.was_setup),
      .sw_clr  (sw_clr),
      .flag_q  (st_flag),
      .side_q  (st_last_setup)
   );

   assign nak_code = RXS_NAK;
   assign tgl_load = {upd.tog_load, {STAT_W{upd.nak_force}}};
   assign tgl_val  = {upd.tog_val, nak_code};
   assign tgl_flip = sw_wdata[TGL_W-1:0] & {TGL_W{sw_wr}};

   for (genvar i = 0; i < TGL_W; i++) begin : g_tgl
      ep_rx_tgl_bit #(
         .RST_VAL (TGL_RST[i])
      ) bit_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .hw_load (tgl_load[i]),
         .hw_val  (tgl_val[i]),
         .sw_flip (tgl_flip[i]),
         .q       (tgl_q[i])
      );
   end

   assign st_toggle = tgl_q[TOG_POS];
   assign st_stat   = tgl_q[STAT_W-1:0];
   assign irq_ep    = st_flag;
   assign irq_gen   = st_flag && irq_en;

endmodule

// File: rtl/ep_rx_ctrl_status_chk.sv
module ep_rx_ctrl_status_chk #(
   parameter int STAT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cfg_kind,
   input logic              irq_en,
   input logic              sw_wr,
   input logic [STAT_W+1:0] sw_wdata,
   input logic              ev_done,
   input logic              ev_setup,
   input logic              ev_data1,
   input logic [1:0]        ev_hs,
   input logic              ev_err,
   input logic              st_flag,
   input logic              st_toggle,
   input logic [STAT_W-1:0] st_stat,
   input logic              st_last_setup,
   input logic              irq_ep,
   input logic              irq_gen
);

   logic out_ok;
   logic sw_tog;
   logic sw_stat;

   assign out_ok  = ev_done && !ev_setup && (cfg_kind != 2'b10) && (ev_hs == 2'b01)
                    && !ev_err && (ev_data1 == st_toggle);
   assign sw_tog  = sw_wr && sw_wdata[STAT_W];
   assign sw_stat = sw_wr && (|sw_wdata[STAT_W-1:0]);

   AST_FLAG_ON_GOOD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      out_ok |=> st_flag); // R1

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_flag && !(sw_wr && !sw_wdata[STAT_W+1])) |=> st_flag); // R1

   AST_NO_FLAG_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_flag && ev_done && (cfg_kind != 2'b10) && ((ev_hs != 2'b01) || ev_err)) |=> !st_flag); // R2

   AST_GOOD_OUT_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ok && !sw_tog) |=> (st_toggle != $past(st_toggle))); // R3

   AST_SETUP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_done && ev_setup && (cfg_kind == 2'b01) && ((ev_hs != 2'b01) || ev_err) && !sw_tog)
      |=> !st_toggle); // R4

   AST_NAK_AFTER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ok && !sw_stat) |=> (st_stat == 2'b10)); // R7

   AST_ISO_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_kind == 2'b10) && !sw_stat) |=> $stable(st_stat)); // R8

   AST_GEN_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_gen |-> (irq_ep && irq_en)); // R10

   AST_EP_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ep == st_flag)); // R10

   AST_LAST_SETUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(st_flag) && !(st_flag && !$stable(st_flag)) && !ev_done |=> $stable(st_last_setup)); // R12

endmodule

bind ep_rx_ctrl_status ep_rx_ctrl_status_chk #(
   .STAT_W (STAT_W)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_kind      (cfg_kind),
   .irq_en        (irq_en),
   .sw_wr         (sw_wr),
   .sw_wdata      (sw_wdata),
   .ev_done       (ev_done),
   .ev_setup      (ev_setup),
   .ev_data1      (ev_data1),
   .ev_hs         (ev_hs),
   .ev_err        (ev_err),
   .st_flag       (st_flag),
   .st_toggle     (st_toggle),
   .st_stat       (st_stat),
   .st_last_setup (st_last_setup),
   .irq_ep        (irq_ep),
   .irq_gen       (irq_gen)
);

// File: tb/ep_rx_ctrl_status_tb_top.sv
module ep_rx_ctrl_status_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_kind = 2'b00;
   logic       irq_en = 1'b0;
   logic       sw_wr = 1'b0;
   logic [3:0] sw_wdata = 4'h0;
   logic       ev_done = 1'b0;
   logic       ev_setup = 1'b0;
   logic       ev_data1 = 1'b0;
   logic [1:0] ev_hs = 2'b00;
   logic       ev_err = 1'b0;
   logic       st_flag, st_toggle, st_last_setup, irq_ep, irq_gen;
   logic [1:0] st_stat;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   logic       m_flag = 0;
   logic       m_tog = 0;
   logic [1:0] m_stat = 2'b00;
   logic       m_last = 0;

   always #2.5 clk = ~clk;

   ep_rx_ctrl_status dut_i (
      .clk (clk), .rst_n (rst_n), .cfg_kind (cfg_kind), .irq_en (irq_en),
      .sw_wr (sw_wr), .sw_wdata (sw_wdata), .ev_done (ev_done), .ev_setup (ev_setup),
      .ev_data1 (ev_data1), .ev_hs (ev_hs), .ev_err (ev_err),
      .st_flag (st_flag), .st_toggle (st_toggle), .st_stat (st_stat),
      .st_last_setup (st_last_setup), .irq_ep (irq_ep), .irq_gen (irq_gen)
   );

   task automatic check(input string tag);
      logic [6:0] act, exp;
      act = {st_flag, st_toggle, st_stat, st_last_setup, irq_ep, irq_gen};
      exp = {m_flag, m_tog, m_stat, m_last, m_flag, m_flag & irq_en};
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: got %b expected %b (flag tog stat last iep igen)", tag, act, exp);
      end
   endtask

   // one clock of stimulus, then model update from the requirements
   task automatic apply(input logic wr, input logic [3:0] wd, input logic dn,
                        input logic st, input logic d1, input logic [1:0] hs,
                        input logic er, input logic [1:0] kind);
      logic hwset, ntog, nlast, ack;
      logic [1:0] nstat;
      sw_wr = wr; sw_wdata = wd; ev_done = dn; ev_setup = st; ev_data1 = d1;
      ev_hs = hs; ev_err = er; cfg_kind = kind;
      @(posedge clk);
      #1;
      sw_wr = 0; sw_wdata = 4'h0; ev_done = 0; ev_setup = 0; ev_data1 = 0;
      ev_hs = 2'b00; ev_err = 0;
      hwset = 0; ntog = m_tog; nstat = m_stat; nlast = m_last;
      ack = (hs == 2'b01) && !er;
      if (dn && st && kind == 2'b01) begin            // R4 control SETUP
         ntog = ack && !d1;
         if (ack && !d1) begin hwset = 1; nstat = 2'b10; nlast = 1; end
      end else if (dn && !st && kind == 2'b10) begin  // R5 isochronous
         ntog = ~m_tog;
         if (!er) begin hwset = 1; nlast = 0; end
      end else if (dn && !st && ack && (d1 == m_tog)) begin // R1 R3 R7
         ntog = ~m_tog; hwset = 1; nstat = 2'b10; nlast = 0;
      end
      if (wr) begin ntog = ntog ^ wd[2]; nstat = nstat ^ wd[1:0]; end // R6 R11
      if (hwset) m_flag = 1;
      else if (wr && !wd[3]) m_flag = 0;
      m_tog = ntog; m_stat = nstat; m_last = nlast;
   endtask

   // drive toggle/status to chosen values; optionally clear the flag
   task automatic set_state(input logic tog, input logic [1:0] stat, input logic clr);
      apply(1'b1, {~clr, tog ^ m_tog, stat ^ m_stat}, 0, 0, 0, 2'b00, 0, 2'b00);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      string tag;
      repeat (3) @(posedge clk);
      #1;
      check("R9 reset state");
      rst_n = 1;
      @(posedge clk); #1;
      check("R9 after reset release");

      // CPU write sweep with flag clear: R6, R1 write-1 no effect
      for (int t = 0; t < 2; t++)
         for (int s = 0; s < 4; s++)
            for (int w = 0; w < 16; w++) begin
               set_state(t[0], s[1:0], 1'b1);
               apply(1'b1, w[3:0], 0, 0, 0, 2'b00, 0, 2'b00);
               check("R6 R1 write sweep");
            end

      // flag set, then write with flag bit 1 (no effect) or 0 (clear): R1 R10
      for (int w = 0; w < 16; w++) begin
         irq_en = w[0];
         apply(0, 4'h0, 1, 0, 0, 2'b00, 0, 2'b10);
         check("R5 R10 iso completion");
         apply(1'b1, w[3:0], 0, 0, 0, 2'b00, 0, 2'b00);
         check("R1 R10 flag write");
      end

      // event sweep over all kinds, PIDs, handshakes, errors, prior states
      for (int k = 0; k < 4; k++)
         for (int su = 0; su < 2; su++)
            for (int p = 0; p < 2; p++)
               for (int h = 0; h < 4; h++)
                  for (int e = 0; e < 2; e++)
                     for (int t = 0; t < 2; t++)
                        for (int s = 0; s < 4; s++)
                           for (int en = 0; en < 2; en++) begin
                              irq_en = en[0];
                              set_state(t[0], s[1:0], 1'b1);
                              apply(0, 4'h0, 1, su[0], p[0], h[1:0], e[0], k[1:0]);
                              if (k == 2 && su == 0) tag = "R5 R8 iso event";
                              else if (su == 1 && k == 1) tag = "R4 R7 control setup";
                              else if (su == 1) tag = "R4 setup on non-control";
                              else if (h == 1 && e == 0 && p == t) tag = "R1 R3 R7 good out";
                              else tag = "R2 rejected out";
                              check(tag);
                              check("R10 interrupts");
                           end

      // R12 sequence: setup completion, failed out, good out
      irq_en = 1;
      set_state(1'b0, 2'b11, 1'b1);
      apply(0, 4'h0, 1, 1, 0, 2'b01, 0, 2'b01);
      check("R12 setup latched");
      apply(0, 4'h0, 1, 0, 0, 2'b10, 0, 2'b01);
      check("R12 held over NAK");
      apply(0, 4'h0, 1, 0, 1, 2'b01, 0, 2'b01);
      check("R12 out latched");

      // R11 collisions
      set_state(1'b0, 2'b11, 1'b1);
      apply(1'b1, 4'b0000, 1, 0, 0, 2'b01, 0, 2'b00);
      check("R11 hw set beats sw clear");
      set_state(1'b1, 2'b11, 1'b1);
      apply(1'b1, 4'b1111, 1, 0, 1, 2'b01, 0, 2'b11);
      check("R11 sw toggle over hw result");
      set_state(1'b0, 2'b01, 1'b1);
      apply(1'b1, 4'b0110, 1, 0, 0, 2'b00, 0, 2'b10);
      check("R11 R8 iso with sw toggle");

      finished = 1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule